// File: doc/BRIEF.md
# UART Receive Buffer and Line Status

This block sits behind a UART deserializer. Each completed character arrives with three flags: parity error, framing error and break. The block stores the character either in a single holding slot or in a 64-entry receive queue. Software reads the head character through a read strobe and reads an 8-bit line status word through a second strobe. Reading the status word clears its error bits.

Error flags travel with each stored character. They reach the status word only when that character becomes the oldest one held. The overrun bit reports a character that had to be dropped because storage was full. The transmit-side status bits are passed through from plain inputs. A queue reset command, or any change of the queue-enable input, empties the storage.

Top module: `uart_rx_lsr`

## Requirements
- R1: Status word bits are: 7 queue enabled (follows `fifo_en_i`), 6 transmitter empty (`tx_empty_i`), 5 transmit request (`tx_req_i`), 4 break, 3 framing error, 2 parity error, 1 overrun, 0 data ready.
- R2: After reset, with `fifo_en_i` low and both transmit inputs high, the status word reads 0x60 and `rbr_data_o` reads 0.
- R3: Data ready is 1 exactly while at least one character is stored. It sets on the cycle after a character is accepted. It clears after the last stored character is popped or after a flush.
- R4: With the queue disabled, at most one character is held. A character that arrives while the slot is full, and is not popped in the same cycle, is lost and sets overrun.
- R5: With the queue enabled, up to 64 characters are held. A character that arrives while all 64 are occupied, and no pop occurs in that cycle, is discarded and sets overrun.
- R6: `rbr_data_o` shows the oldest stored character. A cycle with `rbr_rd_i` high removes it, and characters leave in arrival order.
- R7: The break, framing and parity bits are set from the flags stored with a character when that character becomes the head. Flags of a character that is not yet at the head do not appear.
- R8: The error bits stay set until a cycle with `lsr_rd_i` high clears them. An overrun or head-flag event in that same cycle still leaves its bit set.
- R9: Popping while storage is empty returns 0 on `rbr_data_o` and does not change the stored contents.
- R10: A flush is `fifo_reset_i` high or `fifo_en_i` differing from its value in the previous cycle. A flush empties storage and clears the break, framing and parity bits. A character arriving in a flush cycle is dropped without setting overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = 64-entry queue, 0 = single holding slot |
| fifo_reset_i | input | 1 | Flush receive storage |
| char_valid_i | input | 1 | Completed character strobe |
| char_data_i | input | 8 | Received character |
| char_perr_i | input | 1 | Parity error for this character |
| char_ferr_i | input | 1 | Framing error for this character |
| char_brk_i | input | 1 | Break detected for this character |
| rbr_rd_i | input | 1 | Pop the head character |
| lsr_rd_i | input | 1 | Status word read (clears error bits) |
| tx_empty_i | input | 1 | Transmitter empty, passed to status |
| tx_req_i | input | 1 | Transmit data request, passed to status |
| rbr_data_o | output | 8 | Head character, 0 when empty |
| lsr_o | output | 8 | Line status word |

## Verification
A wrong occupancy count appears at the ports as a data-ready bit that disagrees with the reference queue. It also shows as an overrun that fires too early or too late at the 1- and 64-entry limits, one cycle after the arrival concerned. A misplaced pointer or a wrong head-flag load shows on the next pop, through `rbr_data_o` or through error bits that do not match the character now at the head. A bad clear or set priority shows on the cycle after a status read that coincides with an event.

// File: rtl/uart_rx_lsr_pkg.sv
package uart_rx_lsr_pkg;
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_err_t;

  typedef struct packed {
    rx_err_t    err;
    logic [7:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_store.sv
module rx_store
  import uart_rx_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             cap_one_i,
  input  logic             push_i,
  input  rx_entry_t        entry_i,
  input  logic             pop_i,
  output rx_entry_t        head_o,
  output rx_entry_t        next_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             pop_ok_o
);
  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             full, empty;

  assign empty     = (count == '0);
  assign full      = cap_one_i ? !empty : (count == CNT_W'(DEPTH));
  assign pop_ok_o  = pop_i && !empty && !flush_i;
  assign push_ok_o = push_i && !flush_i && (!full || pop_ok_o);
  assign head_o    = mem[rd_ptr];
  assign next_o    = mem[PTR_W'(rd_ptr + 1'b1)];
  assign count_o   = count;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem[wr_ptr] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok_o) wr_ptr <= PTR_W'(wr_ptr + 1'b1);
      if (pop_ok_o)  rd_ptr <= PTR_W'(rd_ptr + 1'b1);
      case ({push_ok_o, pop_ok_o})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_depth_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));
  assert_single_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_one_i |-> count <= CNT_W'(1));
  assert_empty_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !flush_i && !push_i) |=> ($stable(rd_ptr) && count == '0));
endmodule

// File: rtl/rx_err_track.sv
module rx_err_track
  import uart_rx_lsr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    flush_i,
  input  logic    lsr_rd_i,
  input  logic    ovr_i,
  input  logic    load_i,
  input  rx_err_t flags_i,
  output logic    oe_o,
  output rx_err_t err_o
);
  logic    oe_q;
  rx_err_t err_q;

  // set beats clear: a same-cycle event survives the status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      err_q <= '0;
    end else begin
      oe_q <= (oe_q && !lsr_rd_i) || ovr_i;
      if (flush_i) err_q <= '0;
      else         err_q <= (lsr_rd_i ? rx_err_t'('0) : err_q) | (load_i ? flags_i : rx_err_t'('0));
    end
  end

  assign oe_o  = oe_q;
  assign err_o = err_q;

  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !ovr_i) |=> !oe_o);
  assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> oe_o);
  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> err_o == '0);
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       fifo_reset_i,
  input  logic       char_valid_i,
  input  logic [7:0] char_data_i,
  input  logic       char_perr_i,
  input  logic       char_ferr_i,
  input  logic       char_brk_i,
  input  logic       rbr_rd_i,
  input  logic       lsr_rd_i,
  input  logic       tx_empty_i,
  input  logic       tx_req_i,
  output logic [7:0] rbr_data_o,
  output logic [7:0] lsr_o
);
  logic             mode_q, flush;
  rx_entry_t        in_entry, head, next;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok, ovr_evt, head_load, oe;
  rx_err_t          head_flags, err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= fifo_en_i;
  end

  assign flush    = fifo_reset_i || (fifo_en_i != mode_q);
  assign in_entry = '{err: '{brk: char_brk_i, ferr: char_ferr_i, perr: char_perr_i},
                      data: char_data_i};

  rx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .cap_one_i(!mode_q),
    .push_i   (char_valid_i),
    .entry_i  (in_entry),
    .pop_i    (rbr_rd_i),
    .head_o   (head),
    .next_o   (next),
    .count_o  (count),
    .push_ok_o(push_ok),
    .pop_ok_o (pop_ok)
  );

  assign ovr_evt = char_valid_i && !push_ok && !flush;

  // which entry becomes the head this cycle, if any
  always_comb begin
    head_load  = 1'b0;
    head_flags = '0;
    if (count == '0 && push_ok) begin
      head_load  = 1'b1;
      head_flags = in_entry.err;
    end else if (pop_ok && count >= CNT_W'(2)) begin
      head_load  = 1'b1;
      head_flags = next.err;
    end else if (pop_ok && push_ok) begin
      head_load  = 1'b1;
      head_flags = in_entry.err;
    end
  end

  rx_err_track u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .lsr_rd_i(lsr_rd_i),
    .ovr_i   (ovr_evt),
    .load_i  (head_load),
    .flags_i (head_flags),
    .oe_o    (oe),
    .err_o   (err)
  );

  assign rbr_data_o = (count != '0) ? head.data : 8'h00;
  assign lsr_o = {fifo_en_i, tx_empty_i, tx_req_i, err.brk, err.ferr, err.perr, oe,
                  (count != '0)};

  assert_push_sets_dr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && !pop_ok) |=> lsr_o[0]);
  assert_empty_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsr_o[0] |-> rbr_data_o == 8'h00);
endmodule

// File: tb/uart_rx_lsr_tb.sv
module uart_rx_lsr_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       fifo_en_i = 1'b0, fifo_reset_i = 1'b0, char_valid_i = 1'b0;
  logic [7:0] char_data_i = '0;
  logic       char_perr_i = 1'b0, char_ferr_i = 1'b0, char_brk_i = 1'b0;
  logic       rbr_rd_i = 1'b0, lsr_rd_i = 1'b0, tx_empty_i = 1'b1, tx_req_i = 1'b1;
  logic [7:0] rbr_data_o, lsr_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  bit [10:0] q[$];
  bit        m_oe = 0;
  bit [2:0]  m_err = 0;
  bit        m_mode = 0;

  always #10 clk_i = ~clk_i;

  uart_rx_lsr u_dut (.*);

  function automatic bit [7:0] exp_lsr();
    return {fifo_en_i, tx_empty_i, tx_req_i, m_err, m_oe, q.size() != 0};
  endfunction

  function automatic bit [7:0] exp_rbr();
    return (q.size() != 0) ? q[0][7:0] : 8'h00;
  endfunction

  task automatic check_all(string tag);
    checks++;
    if (lsr_o !== exp_lsr()) begin
      errors++;
      $display("FAIL %s lsr_o actual %02h expected %02h (cycle %0d)", tag, lsr_o, exp_lsr(), cyc);
    end
    checks++;
    if (rbr_data_o !== exp_rbr()) begin
      errors++;
      $display("FAIL %s rbr_data_o actual %02h expected %02h (cycle %0d)", tag, rbr_data_o,
               exp_rbr(), cyc);
    end
  endtask

  // drive one cycle at negedge, advance reference model, land on next negedge
  task automatic cycle(bit v, bit [10:0] e, bit rd, bit lr, bit fr, bit md);
    bit flush, pop, push, have;
    bit [10:0] nh;
    int sz, cap;
    char_valid_i = v;
    {char_brk_i, char_ferr_i, char_perr_i, char_data_i} = e;
    rbr_rd_i = rd; lsr_rd_i = lr; fifo_reset_i = fr; fifo_en_i = md;
    flush = fr || (md != m_mode);
    if (lr) begin m_oe = 0; m_err = 0; end
    if (flush) begin
      q.delete();
      m_err = 0;
    end else begin
      sz = q.size();
      cap = m_mode ? 64 : 1;
      pop = rd && sz > 0;
      push = v && (sz < cap || pop);
      if (v && !push) m_oe = 1;
      have = 0; nh = '0;
      if (sz == 0 && push) begin have = 1; nh = e; end
      else if (pop && sz >= 2) begin have = 1; nh = q[1]; end
      else if (pop && sz == 1 && push) begin have = 1; nh = e; end
      if (have) m_err |= nh[10:8];
      if (pop) void'(q.pop_front());
      if (push) q.push_back(e);
    end
    m_mode = md;
    @(posedge clk_i);
    @(negedge clk_i);
    cyc++;
    char_valid_i = 0; rbr_rd_i = 0; lsr_rd_i = 0; fifo_reset_i = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R2 R1 reset");
    checks++;
    if (lsr_o !== 8'h60) begin
      errors++;
      $display("FAIL R2 reset lsr actual %02h expected 60", lsr_o);
    end

    // R9: pop on empty
    cycle(0, 0, 1, 0, 0, 0);
    check_all("R9 empty pop");

    // R4: single slot overrun, R3 data ready
    cycle(1, 11'h0A5, 0, 0, 0, 0); check_all("R3 R4 hold");
    cycle(1, 11'h05A, 0, 0, 0, 0); check_all("R4 overrun");
    cycle(0, 0, 0, 1, 0, 0);       check_all("R8 read clears");
    // R8: status read together with new overrun
    cycle(1, 11'h033, 0, 1, 0, 0); check_all("R8 event wins");
    cycle(0, 0, 1, 0, 0, 0);       check_all("R3 R6 pop last");
    cycle(0, 0, 0, 1, 0, 0);       check_all("R8 clear");

    // R10: mode change flushes; queue mode
    cycle(1, 11'h011, 0, 0, 0, 0); check_all("R4 refill");
    cycle(1, 11'h022, 0, 0, 0, 1); check_all("R10 mode flush");
    // R7: errored char behind clean head stays hidden
    cycle(1, 11'h001, 0, 0, 0, 1); check_all("R7 clean head");
    cycle(1, 11'h702, 0, 0, 0, 1); check_all("R7 hidden flags");
    cycle(0, 0, 1, 0, 0, 1);       check_all("R7 flags at head");
    cycle(0, 0, 0, 1, 0, 1);       check_all("R8 clear flags");
    cycle(0, 0, 0, 0, 1, 1);       check_all("R10 reset flush");

    // R5: fill 64 then overflow
    for (int i = 0; i < 66; i++) begin
      cycle(1, 11'(i + 8'h40) | (i == 0 ? 11'h100 : 11'h0), 0, 0, 0, 1);
      check_all("R5 fill");
    end
    cycle(1, 11'h0EE, 1, 0, 0, 1); check_all("R5 push with pop at full");
    for (int i = 0; i < 70; i++) begin
      cycle(0, 0, 1, i[2], 0, 1);
      check_all("R6 drain order");
    end

    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit md;
      md = m_mode;
      if ($urandom_range(0, 499) == 0) md = ~md;
      tx_empty_i = 1'($urandom);
      tx_req_i = 1'($urandom);
      cycle($urandom_range(0, 99) < (md ? 60 : 35),
            {($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000, 8'($urandom)},
            $urandom_range(0, 99) < 45,
            $urandom_range(0, 99) < 15,
            $urandom_range(0, 999) < 3,
            md);
      check_all("R1 R3 R5 R6 R7 R8 R10 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule